// File: doc/BRIEF.md
# Two-Wire Register Configuration Slave

This block is the bus-facing half of a configuration port for a peripheral whose registers are 16 bits wide. It watches the clock and data lines of a two-wire open-drain serial bus, bringing both into a faster system clock domain. It recognises start, repeated start and stop conditions and answers to one of four device addresses, which are picked by two strap pins. It acknowledges the bytes it accepts, and on reads it shifts data bytes out onto the data line. It does not hold any register storage.

A register back end sits beside the block. When the master sends a register-address byte, the block hands that byte to the back end as a one-cycle strobe. It hands over each received data byte the same way, with a flag that says whether the byte is the upper or lower half of a word. During reads it asks the back end for each outgoing byte and takes the returned byte in the same cycle. The block keeps the current register pointer and advances it after every complete 16-bit word, so a long burst walks through consecutive registers.

Top module: `tw_cfg_slave`

## Requirements
- R1: The slave acknowledges a device write address of 0x90, 0x98, 0xB0 or 0xB8 when `strap` is 0, 1, 2 or 3. It acknowledges the same value plus one (bit 0 set) as the read address. Acknowledging means pulling SDA low during the ninth clock.
- R2: A device address that does not match the strap selection gets no acknowledge. After it the slave leaves SDA released and raises no back-end strobe until the next start condition.
- R3: The first byte after a matched write address is acknowledged. In the cycle it is handed over, `addr_valid` pulses with that byte on `addr_byte`, and from the next cycle `reg_addr` equals it.
- R4: Each later byte of a write is acknowledged and handed over on `wr_byte_valid` and `wr_byte`. Bytes alternate upper then lower: `wr_low` is 0 for the upper byte and 1 for the lower byte. `reg_addr` names the target register during the strobe.
- R5: `reg_addr` increments by one, wrapping from 0xFF to 0x00, after each complete 16-bit word. This applies to both write and read.
- R6: After a matched read address the slave sends bytes MSB first. For each byte, `rd_byte_req` pulses for one cycle with `rd_low` (0 for the upper byte, 1 for the lower byte) and `reg_addr` valid, and the slave takes `rd_byte` in that same cycle. A read is set up by a register-address write, then a repeated start, then the read address.
- R7: While transmitting, the slave releases SDA during the acknowledge clock. A NACK from the master ends the read: no further `rd_byte_req` is raised and SDA stays released.
- R8: A start or repeated start condition restarts address reception in any state. A stop condition returns the slave to idle with SDA released.
- R9: `sda_oe` rises only while the synchronised SCL is low. The slave never changes SDA while SCL is high.
- R10: `addr_valid`, `wr_byte_valid` and `rd_byte_req` are single-cycle pulses, and at most one of them is high in any cycle.
- R11: During and right after reset, `sda_oe` is 0, all strobes are 0 and `reg_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the SCL rate |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| strap | input | 2 | Device address selection |
| addr_valid | output | 1 | Register-address byte strobe |
| addr_byte | output | 8 | Received register-address byte |
| wr_byte_valid | output | 1 | Received data byte strobe |
| wr_byte | output | 8 | Received data byte |
| wr_low | output | 1 | 0 upper byte, 1 lower byte of the written word |
| rd_byte_req | output | 1 | Request for the next byte to transmit |
| rd_low | output | 1 | 0 upper byte, 1 lower byte of the requested word |
| rd_byte | input | 8 | Byte returned by the back end in the request cycle |
| reg_addr | output | 8 | Current register pointer |

## Verification
All four strap settings are driven with random register addresses, random data and random burst lengths. This separates address decoding from the data path and shows that the strobes carry the right byte, half flag and pointer. Reads are ended on both the upper and the lower byte. These runs tell a correct increment point and NACK termination apart from an off-by-one word boundary. A pointer starting at 0xFF checks the wrap. Addresses that belong to a different strap setting, followed by bytes the slave must ignore, show that the slave does not acknowledge a foreign address and stays quiet until the next start.

// File: rtl/tw_pkg.sv
// Shared definitions for the two-wire configuration slave.
// Assumes an 8-bit byte on the bus and a 7-bit device address field.
package tw_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_REG,
        ST_WDATA,
        ST_RDATA,
        ST_SKIP
    } tw_state_e;

    // Maps the strap pins to the 7-bit device address (without the direction bit).
    function automatic logic [6:0] dev_id(input logic [1:0] sel);
        case (sel)
            2'd0:    dev_id = 7'h48;
            2'd1:    dev_id = 7'h4C;
            2'd2:    dev_id = 7'h58;
            default: dev_id = 7'h5C;
        endcase
    endfunction
endpackage

// File: rtl/tw_line_sync.sv
// Brings SCL and SDA into the system clock domain through a flop chain
// and derives clock edges plus start and stop conditions.
// Assumes the system clock runs at least 8 times the SCL rate.
module tw_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_raw,
    input  logic sda_raw,
    output logic scl_q,
    output logic sda_q,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_prev;
    logic              sda_prev;

    // Synchroniser chains and one-cycle history; idle bus reads high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_raw};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_raw};
            scl_prev <= scl_q;
            sda_prev <= sda_q;
        end
    end

    // Edge and condition decode on the synchronised lines.
    always_comb begin
        scl_q    = scl_pipe[STAGES-1];
        sda_q    = sda_pipe[STAGES-1];
        scl_rise = scl_q & ~scl_prev;
        scl_fall = ~scl_q & scl_prev;
        start_ev = scl_q & scl_prev & sda_prev & ~sda_q;
        stop_ev  = scl_q & scl_prev & ~sda_prev & sda_q;
    end
endmodule

// File: rtl/tw_dev_match.sv
// Compares a received device byte against the strap-selected address.
// Assumes bit 0 of the byte is the direction (0 write, 1 read).
module tw_dev_match
    import tw_pkg::*;
(
    input  logic [1:0]        strap,
    input  logic [BYTE_W-1:0] dev_byte,
    output logic              hit_wr,
    output logic              hit_rd
);
    logic id_hit;

    // Address compare and direction split.
    always_comb begin
        id_hit = (dev_byte[BYTE_W-1:1] == dev_id(strap));
        hit_wr = id_hit & ~dev_byte[0];
        hit_rd = id_hit & dev_byte[0];
    end
endmodule

// File: rtl/tw_word_ptr.sv
// Holds the register pointer and the upper/lower half flag of a 16-bit word.
// A load sets the pointer and restarts at the upper half; each advance
// toggles the half and bumps the pointer after the lower half.
module tw_word_ptr #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          advance,
    output logic [AW-1:0] ptr,
    output logic          low
);
    // Pointer and half-word tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
            low <= 1'b0;
        end else if (load) begin
            ptr <= load_val;
            low <= 1'b0;
        end else if (advance) begin
            if (low) begin
                ptr <= ptr + AW'(1);
            end
            low <= ~low;
        end
    end
endmodule

// File: rtl/tw_cfg_slave.sv
// Two-wire bus slave for a 16-bit register file: address match from straps,
// register-address capture, word-ordered byte hand-off and read shifting.
// Assumes no clock stretching, 7-bit addressing and a back end that returns
// rd_byte combinationally in the cycle rd_byte_req is high.
module tw_cfg_slave
    import tw_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_oe,
    input  logic [1:0]        strap,
    output logic              addr_valid,
    output logic [BYTE_W-1:0] addr_byte,
    output logic              wr_byte_valid,
    output logic [BYTE_W-1:0] wr_byte,
    output logic              wr_low,
    output logic              rd_byte_req,
    output logic              rd_low,
    input  logic [BYTE_W-1:0] rd_byte,
    output logic [BYTE_W-1:0] reg_addr
);
    localparam logic [CNT_W-1:0] BITS_DONE = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] ACK_SLOT  = CNT_W'(BYTE_W + 1);

    logic scl_q, sda_q, scl_rise, scl_fall, start_ev, stop_ev;
    logic hit_wr, hit_rd;
    logic ptr_low, rd_advance;

    tw_state_e         st, nxt;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] rx_sh;
    logic [BYTE_W-1:0] tx_sh;
    logic              oe_q;

    tw_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_raw  (scl_in),
        .sda_raw  (sda_in),
        .scl_q    (scl_q),
        .sda_q    (sda_q),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    tw_dev_match u_match (
        .strap    (strap),
        .dev_byte (rx_sh),
        .hit_wr   (hit_wr),
        .hit_rd   (hit_rd)
    );

    tw_word_ptr #(.AW(BYTE_W)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (addr_valid),
        .load_val (rx_sh),
        .advance  (wr_byte_valid | rd_advance),
        .ptr      (reg_addr),
        .low      (ptr_low)
    );

    // Back-end strobes, all derived from registered state and one-cycle edges.
    always_comb begin
        addr_valid    = (st == ST_REG) && scl_fall && (cnt == BITS_DONE);
        addr_byte     = rx_sh;
        wr_byte_valid = (st == ST_WDATA) && scl_fall && (cnt == BITS_DONE);
        wr_byte       = rx_sh;
        wr_low        = ptr_low;
        rd_advance    = (st == ST_RDATA) && scl_rise && (cnt == ACK_SLOT);
        rd_byte_req   = scl_fall && (cnt == ACK_SLOT) &&
                        (((st == ST_DEV) && (nxt == ST_RDATA)) || (st == ST_RDATA));
        rd_low        = ptr_low;
        sda_oe        = oe_q;
    end

    // Bus protocol sequencer: bit counting, acknowledge and shift-out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= ST_IDLE;
            nxt   <= ST_IDLE;
            cnt   <= '0;
            rx_sh <= '0;
            tx_sh <= '0;
            oe_q  <= 1'b0;
        end else if (stop_ev) begin
            st   <= ST_IDLE;
            oe_q <= 1'b0;
        end else if (start_ev) begin
            st   <= ST_DEV;
            cnt  <= '0;
            oe_q <= 1'b0;
        end else begin
            case (st)
                ST_DEV, ST_REG, ST_WDATA: begin
                    if (scl_rise && (cnt < BITS_DONE)) begin
                        rx_sh <= {rx_sh[BYTE_W-2:0], sda_q};
                        cnt   <= cnt + CNT_W'(1);
                    end else if (scl_fall && (cnt == BITS_DONE)) begin
                        cnt <= ACK_SLOT;
                        if (st == ST_DEV) begin
                            if (hit_wr) begin
                                oe_q <= 1'b1;
                                nxt  <= ST_REG;
                            end else if (hit_rd) begin
                                oe_q <= 1'b1;
                                nxt  <= ST_RDATA;
                            end else begin
                                st <= ST_SKIP;
                            end
                        end else begin
                            oe_q <= 1'b1;
                            nxt  <= ST_WDATA;
                        end
                    end else if (scl_fall && (cnt == ACK_SLOT)) begin
                        st <= nxt;
                        if (nxt == ST_RDATA) begin
                            oe_q  <= ~rd_byte[BYTE_W-1];
                            tx_sh <= {rd_byte[BYTE_W-2:0], 1'b0};
                            cnt   <= CNT_W'(1);
                        end else begin
                            oe_q <= 1'b0;
                            cnt  <= '0;
                        end
                    end
                end
                ST_RDATA: begin
                    if (scl_fall && (cnt != '0) && (cnt < BITS_DONE)) begin
                        oe_q  <= ~tx_sh[BYTE_W-1];
                        tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
                        cnt   <= cnt + CNT_W'(1);
                    end else if (scl_fall && (cnt == BITS_DONE)) begin
                        oe_q <= 1'b0;
                        cnt  <= ACK_SLOT;
                    end else if (scl_rise && (cnt == ACK_SLOT)) begin
                        if (sda_q) begin
                            st <= ST_SKIP;
                        end
                    end else if (scl_fall && (cnt == ACK_SLOT)) begin
                        oe_q  <= ~rd_byte[BYTE_W-1];
                        tx_sh <= {rd_byte[BYTE_W-2:0], 1'b0};
                        cnt   <= CNT_W'(1);
                    end
                end
                default: begin
                    oe_q <= 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/tw_cfg_slave_chk.sv
// Property checker for tw_cfg_slave, attached with bind below.
module tw_cfg_slave_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_q,
    input logic       sda_oe,
    input logic       addr_valid,
    input logic [7:0] addr_byte,
    input logic       wr_byte_valid,
    input logic       wr_low,
    input logic       rd_byte_req,
    input logic [7:0] reg_addr
);
    // R9: the slave starts pulling SDA only while SCL is low.
    assert_drive_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> $past(!scl_q));

    // R10: strobes never overlap.
    assert_strobe_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({addr_valid, wr_byte_valid, rd_byte_req}));

    // R10: write strobe lasts one cycle.
    assert_wr_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_byte_valid |=> !wr_byte_valid);

    // R3: the pointer takes the register-address byte.
    assert_ptr_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid |=> (reg_addr == $past(addr_byte)));

    // R5: a completed word moves the pointer on by one.
    assert_ptr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_byte_valid && wr_low) |=> (reg_addr == $past(reg_addr) + 8'd1));

    // R4: the upper byte leaves the pointer in place.
    assert_ptr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_byte_valid && !wr_low) |=> $stable(reg_addr));
endmodule

bind tw_cfg_slave tw_cfg_slave_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .scl_q         (scl_q),
    .sda_oe        (sda_oe),
    .addr_valid    (addr_valid),
    .addr_byte     (addr_byte),
    .wr_byte_valid (wr_byte_valid),
    .wr_low        (wr_low),
    .rd_byte_req   (rd_byte_req),
    .reg_addr      (reg_addr)
);

// File: tb/tw_cfg_slave_tb.sv
// Self-checking bench: bus master model, combinational back-end model,
// random transfers with a fixed seed plus directed corner cases.
module tw_cfg_slave_tb;
    localparam int H = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       m_scl, m_sda;
    logic       sda_in, sda_oe;
    logic [1:0] strap;
    logic       addr_valid, wr_byte_valid, wr_low, rd_byte_req, rd_low;
    logic [7:0] addr_byte, wr_byte, rd_byte, reg_addr;

    logic [15:0] mem [256];
    int tests = 0, fails = 0;
    int a_cnt = 0, w_cnt = 0, r_cnt = 0, ovl = 0, viol = 0;
    logic [7:0]  a_last;
    logic [16:0] wlog [64];
    logic [8:0]  rlog [64];
    logic [7:0]  wd [64];
    bit done = 0;

    always #2 clk = ~clk;

    assign sda_in  = m_sda & ~sda_oe;
    assign rd_byte = rd_low ? mem[reg_addr][7:0] : mem[reg_addr][15:8];

    tw_cfg_slave u_dut (
        .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_in), .sda_oe(sda_oe),
        .strap(strap), .addr_valid(addr_valid), .addr_byte(addr_byte),
        .wr_byte_valid(wr_byte_valid), .wr_byte(wr_byte), .wr_low(wr_low),
        .rd_byte_req(rd_byte_req), .rd_low(rd_low), .rd_byte(rd_byte),
        .reg_addr(reg_addr)
    );

    // Strobe logger, sampled mid-cycle.
    always @(negedge clk) begin
        if (rst_n) begin
            if (int'(addr_valid) + int'(wr_byte_valid) + int'(rd_byte_req) > 1) ovl++;
            if (addr_valid) begin a_cnt++; a_last = addr_byte; end
            if (wr_byte_valid) begin
                if (w_cnt < 64) wlog[w_cnt] = {reg_addr, wr_low, wr_byte};
                w_cnt++;
            end
            if (rd_byte_req) begin
                if (r_cnt < 64) rlog[r_cnt] = {reg_addr, rd_low};
                r_cnt++;
            end
        end
    end

    // R9 watch: any change of the slave drive while SCL is high.
    always @(sda_oe) if (rst_n === 1'b1 && m_scl) viol++;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] dev_wr(input logic [1:0] s);
        case (s)
            2'd0: return 8'h90;
            2'd1: return 8'h98;
            2'd2: return 8'hB0;
            default: return 8'hB8;
        endcase
    endfunction

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wt(H); m_scl = 1'b1; wt(H); m_sda = 1'b0; wt(H); m_scl = 1'b0; wt(2);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wt(H); m_scl = 1'b1; wt(H); m_sda = 1'b1; wt(H);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; wt(H - 2); m_scl = 1'b1; wt(H); m_scl = 1'b0; wt(2);
        end
        m_sda = 1'b1; wt(H - 2); m_scl = 1'b1; wt(H / 2);
        ack = (sda_in == 1'b0);
        wt(H / 2); m_scl = 1'b0; wt(2);
    endtask

    task automatic recv_byte(input bit nack, output logic [7:0] b, output bit rel);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wt(H - 2); m_scl = 1'b1; wt(H / 2); b[i] = sda_in; wt(H / 2); m_scl = 1'b0; wt(2);
        end
        m_sda = nack; wt(H - 2); m_scl = 1'b1; wt(H / 2);
        rel = !sda_oe;
        wt(H / 2); m_scl = 1'b0; wt(2); m_sda = 1'b1;
    endtask

    task automatic write_txn(input logic [7:0] ra, input int nw);
        int a0, w0;
        bit ack;
        a0 = a_cnt; w0 = w_cnt;
        bus_start();
        send_byte(dev_wr(strap), ack);
        chk(ack, "R1 write address ack", ack, 1);
        send_byte(ra, ack);
        chk(ack, "R3 register address ack", ack, 1);
        chk(a_cnt == a0 + 1 && a_last == ra, "R3 addr strobe", a_last, ra);
        for (int k = 0; k < 2 * nw; k++) begin
            wd[k] = 8'($urandom);
            send_byte(wd[k], ack);
            chk(ack, "R4 data ack", ack, 1);
        end
        bus_stop();
        chk(w_cnt == w0 + 2 * nw, "R4 strobe count", w_cnt - w0, 2 * nw);
        for (int k = 0; k < 2 * nw; k++) begin
            chk(wlog[w0 + k][8:0] == {k[0], wd[k]}, "R4 byte and half",
                wlog[w0 + k][8:0], {k[0], wd[k]});
            chk(wlog[w0 + k][16:9] == 8'(ra + k / 2), "R5 write pointer",
                wlog[w0 + k][16:9], 8'(ra + k / 2));
        end
    endtask

    task automatic read_txn(input logic [7:0] ra, input int nb);
        int r0;
        bit ack, rel;
        logic [7:0] b, ea;
        bus_start();
        send_byte(dev_wr(strap), ack);
        send_byte(ra, ack);
        bus_start();
        send_byte(dev_wr(strap) | 8'h01, ack);
        chk(ack, "R1 R8 read address ack after repeated start", ack, 1);
        r0 = r_cnt;
        for (int k = 0; k < nb; k++) begin
            recv_byte(k == nb - 1, b, rel);
            ea = 8'(ra + k / 2);
            chk(b == (k[0] ? mem[ea][7:0] : mem[ea][15:8]), "R6 read byte", b,
                k[0] ? mem[ea][7:0] : mem[ea][15:8]);
            chk(rel, "R7 released in ack clock", rel, 1);
            chk(rlog[r0 + k] == {ea, k[0]}, "R5 R6 read pointer and half",
                rlog[r0 + k], {ea, k[0]});
        end
        wt(3 * H);
        chk(r_cnt == r0 + nb, "R7 no request after NACK", r_cnt - r0, nb);
        chk(!sda_oe, "R7 SDA released after NACK", sda_oe, 0);
        bus_stop();
        chk(!sda_oe, "R8 released after stop", sda_oe, 0);
    endtask

    task automatic foreign_txn(input logic [7:0] dev);
        int a0, w0, r0;
        bit ack;
        a0 = a_cnt; w0 = w_cnt; r0 = r_cnt;
        bus_start();
        send_byte(dev, ack);
        chk(!ack, "R2 foreign address not acked", ack, 0);
        for (int k = 0; k < 3; k++) begin
            send_byte(8'($urandom), ack);
            chk(!ack, "R2 byte ignored", ack, 0);
        end
        bus_stop();
        chk(a_cnt == a0 && w_cnt == w0 && r_cnt == r0, "R2 no strobes",
            a_cnt + w_cnt + r_cnt - a0 - w0 - r0, 0);
    endtask

    initial begin
        int seed;
        seed  = $urandom(32'h1D2C);
        rst_n = 1'b0; m_scl = 1'b1; m_sda = 1'b1; strap = 2'd0;
        for (int i = 0; i < 256; i++) mem[i] = 16'($urandom);
        wt(5);
        chk(!sda_oe && !addr_valid && !wr_byte_valid && !rd_byte_req && reg_addr == 8'h00,
            "R11 reset state", {sda_oe, reg_addr}, 0);
        rst_n = 1'b1;
        wt(5);
        chk(!sda_oe && reg_addr == 8'h00, "R11 after reset", {sda_oe, reg_addr}, 0);

        // Directed: every strap value, plus a foreign address.
        for (int s = 0; s < 4; s++) begin
            strap = 2'(s);
            write_txn(8'h09, 1);
            read_txn(8'h09, 2);
            foreign_txn(dev_wr(2'(s + 1)));
            foreign_txn(dev_wr(2'(s + 2)) | 8'h01);
        end
        // Directed: pointer wrap and a read ending on an upper byte.
        strap = 2'd3;
        write_txn(8'hFF, 2);
        read_txn(8'hFF, 3);

        // Random mix.
        for (int it = 0; it < 8; it++) begin
            logic [7:0] ra;
            int nw;
            strap = 2'($urandom);
            ra    = 8'($urandom);
            nw    = 1 + int'($urandom % 3);
            write_txn(ra, nw);
            read_txn(ra, 1 + int'($urandom % 5));
            if (it % 3 == 0) foreign_txn(8'($urandom) & 8'h0F);
        end

        chk(ovl == 0, "R10 strobe overlap", ovl, 0);
        chk(viol == 0, "R9 SDA change with SCL high", viol, 0);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule